// File: doc/BRIEF.md
# Low-Power Auto-Reload Event Timer

This block is a memory-mapped timer that generates wake-up events. A 16-bit up-counter advances once per prescaler tick. The prescaler divides the block clock by a power of two from 1 to 128. When the count equals the programmed reload value, the counter returns to zero, a sticky match flag is set, and an interrupt line goes high if the match interrupt is enabled. Because the count restarts at every match, the counter marks intervals and is not a free-running time base.

The host uses a small register bank over a synchronous bus. Writes take one cycle. Reads are registered, with a 3-bit word address and 32-bit data. Some registers can only be written in a given enable state. The interrupt enable can be written only while the timer is disabled. The reload value can be written only while it is enabled. A start command picks between a one-shot run and continuous counting.

Top module: `lpwr_evt_timer`

## Requirements
- R1: After reset every register reads zero except the reload register, which reads 0x0000FFFF, and `irq_out` is low. Word addresses: 0 status, 1 flag clear, 2 interrupt enable, 3 configuration, 4 control, 5 reload; addresses 6 and 7 read zero.
- R2: Control bit 0 is the enable, bit 1 requests a one-shot start and bit 2 requests a continuous start. A start request acts only in a write that also has bit 0 set. Start bits read back as 0.
- R3: A write to the interrupt-enable register (match enable at bit 1) is ignored while the timer is enabled.
- R4: A write to the reload register (bits 15:0) is ignored while the timer is disabled.
- R5: After a start, the match flag (status bit 1) is set at the (R+1)·2^N-th rising edge after the start edge. R is the reload value and N is configuration bits 11:9.
- R6: In a one-shot run the counter stops after the match and produces no further match.
- R7: In continuous mode the count wraps to zero at each match, and matches repeat every (R+1)·2^N cycles.
- R8: The match flag stays set until a write of 1 to bit 1 of the flag-clear register. A match in the same cycle as a clear wins.
- R9: `irq_out` is high exactly when the match flag and the match interrupt enable are both set.
- R10: Writing 0 to control disables the timer and stops it. It also clears the counter and the prescaler divider, so the next start counts a full period. A pending flag is kept.
- R11: A continuous start issued during a one-shot run switches that run to continuous without restarting the count.
- R12: Read data appears on `bus_rdata` one cycle after the address is presented. Unused bits read zero, including the write-only flag-clear register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 3 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_out | output | 1 | Match interrupt (flag AND enable) |

## Verification
The hardest situation to reach from the ports is a continuous start that lands in the middle of a one-shot run. The bench starts a one-shot run and, in the very next cycle, writes a continuous start. It then looks for a second match one full period after the first, which would not occur if the run had stayed one-shot. The second hard case is a match flag pending while the interrupt is masked. Since the enable only accepts writes when the timer is disabled, the bench lets a masked match occur, disables the timer, sets the enable and checks that the interrupt rises from the retained flag. Table-driven runs then sweep reload values and prescaler settings, including the largest divider, and check the exact edge at which each event appears.

// File: rtl/lpet_pkg.sv
package lpet_pkg;

    localparam int DATA_W = 32;
    localparam int ADDR_W = 3;
    localparam int PSC_W  = 3;
    localparam int DIV_W  = (1 << PSC_W) - 1;

    // bit positions inside the registers
    localparam int CTL_EN_BIT   = 0;
    localparam int CTL_ONCE_BIT = 1;
    localparam int CTL_LOOP_BIT = 2;
    localparam int MATCH_BIT    = 1;
    localparam int PSC_LSB      = 9;

    typedef enum logic [ADDR_W-1:0] {
        A_STAT = 3'd0,
        A_CLR  = 3'd1,
        A_IEN  = 3'd2,
        A_CFG  = 3'd3,
        A_CTRL = 3'd4,
        A_ARR  = 3'd5
    } reg_addr_e;

    typedef enum logic {
        RUN_ONCE = 1'b0,
        RUN_LOOP = 1'b1
    } run_mode_e;

    // decoded control-register write
    typedef struct packed {
        logic wr;
        logic en;
        logic go_once;
        logic go_loop;
    } ctl_req_t;

    function automatic logic [DIV_W-1:0] div_mask(input logic [PSC_W-1:0] n);
        logic [DIV_W:0] full;
        full = ({{DIV_W{1'b0}}, 1'b1} << n) - 1'b1;
        return full[DIV_W-1:0];
    endfunction

endpackage

// File: rtl/lpet_regbank.sv
module lpet_regbank
    import lpet_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    we,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [DATA_W-1:0]       wdata,
    input  logic                    match_evt,
    output logic                    en_q,
    output logic                    ie_q,
    output logic                    flag_q,
    output logic [PSC_W-1:0]        psc_q,
    output logic [CNT_W-1:0]        arr_q,
    output ctl_req_t                req,
    output logic [DATA_W-1:0]       rdata
);

    logic wr_ctrl, wr_ien, wr_cfg, wr_arr, wr_clr;
    logic [DATA_W-1:0] rmux;

    assign wr_ctrl = we && (addr == A_CTRL);
    assign wr_ien  = we && (addr == A_IEN);
    assign wr_cfg  = we && (addr == A_CFG);
    assign wr_arr  = we && (addr == A_ARR);
    assign wr_clr  = we && (addr == A_CLR);

    assign req.wr      = wr_ctrl;
    assign req.en      = wdata[CTL_EN_BIT];
    assign req.go_once = wdata[CTL_ONCE_BIT];
    assign req.go_loop = wdata[CTL_LOOP_BIT];

    generate
        if (CNT_W < DATA_W) begin : g_hi
            logic unused_hi;
            assign unused_hi = ^wdata[DATA_W-1:CNT_W];
        end
    endgenerate

    always_comb begin
        rmux = '0;
        case (addr)
            A_STAT: rmux[MATCH_BIT] = flag_q;
            A_IEN:  rmux[MATCH_BIT] = ie_q;
            A_CFG:  rmux[PSC_LSB +: PSC_W] = psc_q;
            A_CTRL: rmux[CTL_EN_BIT] = en_q;
            A_ARR:  rmux[CNT_W-1:0] = arr_q;
            default: rmux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q   <= 1'b0;
            ie_q   <= 1'b0;
            flag_q <= 1'b0;
            psc_q  <= '0;
            arr_q  <= '1;
            rdata  <= '0;
        end else begin
            if (wr_ctrl)
                en_q <= wdata[CTL_EN_BIT];
            if (wr_ien && !en_q)
                ie_q <= wdata[MATCH_BIT];
            if (wr_cfg)
                psc_q <= wdata[PSC_LSB +: PSC_W];
            if (wr_arr && en_q)
                arr_q <= wdata[CNT_W-1:0];
            if (match_evt)
                flag_q <= 1'b1;
            else if (wr_clr && wdata[MATCH_BIT])
                flag_q <= 1'b0;
            rdata <= rmux;
        end
    end

endmodule

// File: rtl/lpet_prescaler.sv
module lpet_prescaler
    import lpet_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             active,
    input  logic [PSC_W-1:0] n,
    output logic             tick
);

    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] mask;

    assign mask = div_mask(n);
    assign tick = active && ((div_q & mask) == mask);

    always_ff @(posedge clk) begin
        if (rst || !active)
            div_q <= '0;
        else
            div_q <= div_q + 1'b1;
    end

endmodule

// File: rtl/lpet_counter.sv
module lpet_counter
    import lpet_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  ctl_req_t         req,
    input  logic             tick,
    input  logic [CNT_W-1:0] arr,
    output logic             run_q,
    output logic [CNT_W-1:0] cnt_q,
    output logic             match_evt
);

    run_mode_e        mode_q, mode_n;
    logic             run_n;
    logic [CNT_W-1:0] cnt_n;
    logic             start_now, stop_now;

    assign match_evt = run_q && tick && (cnt_q == arr);
    assign start_now = req.wr && req.en && (req.go_once || req.go_loop);
    assign stop_now  = req.wr && !req.en;

    always_comb begin
        cnt_n  = cnt_q;
        run_n  = run_q;
        mode_n = mode_q;
        if (match_evt) begin
            cnt_n = '0;
            if (mode_q == RUN_ONCE)
                run_n = 1'b0;
        end else if (run_q && tick) begin
            cnt_n = cnt_q + 1'b1;
        end
        if (start_now) begin
            if (req.go_loop) begin
                mode_n = RUN_LOOP;
                run_n  = 1'b1;
            end else if (!run_q) begin
                mode_n = RUN_ONCE;
                run_n  = 1'b1;
                cnt_n  = '0;
            end
        end
        if (stop_now) begin
            run_n = 1'b0;
            cnt_n = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q  <= 1'b0;
            mode_q <= RUN_ONCE;
            cnt_q  <= '0;
        end else begin
            run_q  <= run_n;
            mode_q <= mode_n;
            cnt_q  <= cnt_n;
        end
    end

endmodule

// File: rtl/lpwr_evt_timer.sv
module lpwr_evt_timer
    import lpet_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_out
);

    logic             en_q, ie_q, flag_q, run_q, match_evt, tick;
    logic [PSC_W-1:0] psc_q;
    logic [CNT_W-1:0] arr_q, cnt_q;
    ctl_req_t         req;

    lpet_regbank #(.CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst(rst), .we(bus_we), .addr(bus_addr), .wdata(bus_wdata),
        .match_evt(match_evt), .en_q(en_q), .ie_q(ie_q), .flag_q(flag_q),
        .psc_q(psc_q), .arr_q(arr_q), .req(req), .rdata(bus_rdata)
    );

    lpet_prescaler u_psc (
        .clk(clk), .rst(rst), .active(run_q), .n(psc_q), .tick(tick)
    );

    lpet_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst(rst), .req(req), .tick(tick), .arr(arr_q),
        .run_q(run_q), .cnt_q(cnt_q), .match_evt(match_evt)
    );

    assign irq_out = flag_q & ie_q;

endmodule

// File: rtl/lpet_checker.sv
module lpet_checker #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             bus_we,
    input logic [2:0]       bus_addr,
    input logic             clr_bit,
    input logic             en_q,
    input logic             ie_q,
    input logic             flag_q,
    input logic             run_q,
    input logic [CNT_W-1:0] cnt_q,
    input logic [CNT_W-1:0] arr_q
);

    // R10
    idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !run_q |-> (cnt_q == '0));

    // R2
    run_needs_en_chk: assert property (@(posedge clk) disable iff (rst)
        run_q |-> en_q);

    // R3
    ien_lock_chk: assert property (@(posedge clk) disable iff (rst)
        en_q |=> $stable(ie_q));

    // R4
    arr_lock_chk: assert property (@(posedge clk) disable iff (rst)
        !en_q |=> $stable(arr_q));

    // R8
    flag_fall_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(flag_q) |-> $past(bus_we && (bus_addr == 3'd1) && clr_bit));

    // R6
    once_end_chk: assert property (@(posedge clk) disable iff (rst)
        ($fell(run_q) && en_q) |-> flag_q);

    // R5
    flag_src_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(flag_q) |-> $past(run_q));

endmodule

bind lpwr_evt_timer lpet_checker #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
    .clr_bit(bus_wdata[1]), .en_q(en_q), .ie_q(ie_q), .flag_q(flag_q),
    .run_q(run_q), .cnt_q(cnt_q), .arr_q(arr_q)
);

// File: tb/tb_lpwr_evt_timer.sv
module tb_lpwr_evt_timer;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        we = 1'b0;
    logic [2:0]  addr = 3'd0;
    logic [31:0] wdata = 32'd0;
    logic [31:0] rdata;
    logic        irq;
    int          nvec = 0;
    int          nbad = 0;

    localparam logic [2:0] STAT = 3'd0, CLR = 3'd1, IEN = 3'd2,
                           CFG = 3'd3, CTRL = 3'd4, ARR = 3'd5;

    typedef struct packed {
        logic [15:0] arr;
        logic [2:0]  n;
        logic [15:0] per;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VT [NV] = '{
        '{16'd3, 3'd0, 16'd4},
        '{16'd1, 3'd0, 16'd2},
        '{16'd5, 3'd1, 16'd12},
        '{16'd2, 3'd3, 16'd24},
        '{16'd4, 3'd2, 16'd20},
        '{16'd1, 3'd7, 16'd256},
        '{16'd9, 3'd0, 16'd10}
    };

    always #4 clk = ~clk;

    lpwr_evt_timer dut (
        .clk(clk), .rst(rst), .bus_we(we), .bus_addr(addr),
        .bus_wdata(wdata), .bus_rdata(rdata), .irq_out(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        nvec++;
        if (act !== exp) begin
            nbad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // called at a negedge, returns at the negedge after the write edge
    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        we = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        we = 1'b0; wdata = 32'd0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] v);
        addr = a;
        @(negedge clk);
        v = rdata;
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nbad++;
        $display("FAIL watchdog actual=running expected=done");
        finish_run();
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        check("R1 irq", {31'd0, irq}, 32'd0);
        for (int a = 0; a < 8; a++) begin
            rd(3'(a), v);
            check("R1 reset read", v, (a == 5) ? 32'h0000FFFF : 32'd0);
        end

        // R4 reload write ignored while disabled
        wr(ARR, 32'd5);
        rd(ARR, v);
        check("R4 reload locked", v, 32'h0000FFFF);

        // R3 enable write ignored while enabled
        wr(CTRL, 32'd1);
        wr(IEN, 32'd2);
        rd(IEN, v);
        check("R3 ien locked", v, 32'd0);

        // R12 unused bits read zero
        wr(CFG, 32'hFFFFFFFF);
        rd(CFG, v);
        check("R12 cfg mask", v, 32'h00000E00);
        wr(CFG, 32'd0);

        // R2 start without enable, enable without start
        wr(CTRL, 32'd0);
        wr(IEN, 32'd2);
        wr(CTRL, 32'd1);
        wr(ARR, 32'd1);
        wr(CTRL, 32'd0);
        wr(CTRL, 32'd6);
        wait_n(10);
        check("R2 start needs enable", {31'd0, irq}, 32'd0);
        wr(CTRL, 32'd1);
        wait_n(10);
        check("R2 enable alone no run", {31'd0, irq}, 32'd0);
        wr(CTRL, 32'd3);
        wait_n(1);
        check("R2 before match", {31'd0, irq}, 32'd0);
        wait_n(1);
        check("R2 one-shot match", {31'd0, irq}, 32'd1);
        rd(CTRL, v);
        check("R2 start bits read 0", v, 32'd1);

        // R9 masked flag, R10 flag kept across disable
        wr(CTRL, 32'd0);
        wr(IEN, 32'd0);
        wr(CLR, 32'd2);
        wr(CTRL, 32'd1);
        wr(ARR, 32'd2);
        wr(CTRL, 32'd3);
        wait_n(3);
        check("R9 masked irq", {31'd0, irq}, 32'd0);
        rd(STAT, v);
        check("R5 status flag", v, 32'd2);
        wr(CTRL, 32'd0);
        rd(STAT, v);
        check("R10 flag kept", v, 32'd2);
        wr(IEN, 32'd2);
        check("R9 irq on enable", {31'd0, irq}, 32'd1);
        wr(CLR, 32'd2);
        check("R8 clear", {31'd0, irq}, 32'd0);

        // R10 disable mid-run, restart counts full period
        wr(CTRL, 32'd1);
        wr(ARR, 32'd5);
        wr(CTRL, 32'd3);
        wait_n(3);
        wr(CTRL, 32'd0);
        check("R10 stopped", {31'd0, irq}, 32'd0);
        wr(CTRL, 32'd3);
        wait_n(5);
        check("R10 full period pre", {31'd0, irq}, 32'd0);
        wait_n(1);
        check("R10 full period", {31'd0, irq}, 32'd1);
        wr(CLR, 32'd2);

        // R7 continuous repeats
        wr(ARR, 32'd2);
        wr(CTRL, 32'd5);
        wait_n(2);
        check("R7 pre", {31'd0, irq}, 32'd0);
        wait_n(1);
        check("R7 first", {31'd0, irq}, 32'd1);
        wr(CLR, 32'd2);
        check("R7 cleared", {31'd0, irq}, 32'd0);
        wait_n(1);
        check("R7 gap", {31'd0, irq}, 32'd0);
        wait_n(1);
        check("R7 second", {31'd0, irq}, 32'd1);
        wr(CTRL, 32'd0);

        // R11 continuous start during one-shot
        wr(CLR, 32'd2);
        wr(CTRL, 32'd1);
        wr(ARR, 32'd3);
        wr(CTRL, 32'd3);
        wr(CTRL, 32'd5);
        wait_n(2);
        check("R11 pre", {31'd0, irq}, 32'd0);
        wait_n(1);
        check("R11 first", {31'd0, irq}, 32'd1);
        wr(CLR, 32'd2);
        wait_n(2);
        check("R11 gap", {31'd0, irq}, 32'd0);
        wait_n(1);
        check("R11 second", {31'd0, irq}, 32'd1);
        wr(CTRL, 32'd0);

        // R5 R6 R8 table of reload / prescaler settings
        for (int i = 0; i < NV; i++) begin
            wr(CTRL, 32'd0);
            wr(IEN, 32'd2);
            wr(CLR, 32'd2);
            wr(CFG, {20'd0, VT[i].n, 9'd0});
            wr(CTRL, 32'd1);
            wr(ARR, {16'd0, VT[i].arr});
            wr(CTRL, 32'd3);
            wait_n(int'(VT[i].per) - 1);
            check("R5 before match", {31'd0, irq}, 32'd0);
            wait_n(1);
            check("R5 match edge", {31'd0, irq}, 32'd1);
            wait_n(3);
            check("R8 sticky", {31'd0, irq}, 32'd1);
            wr(CLR, 32'd2);
            check("R8 cleared", {31'd0, irq}, 32'd0);
            wait_n(int'(VT[i].per) + 2);
            check("R6 one-shot stopped", {31'd0, irq}, 32'd0);
        end

        finish_run();
    end

endmodule